// File: doc/BRIEF.md
# Cache Way Lockdown and Victim Selector

This block decides which way of a set-associative cache receives a new line on a linefill. Each request carries the set index, the valid bit of every way in that set, the identity of the requesting master (one of eight) and whether the access fetches instructions or data. The answer arrives one cycle later. It is either a victim way or a flag saying the line must not be allocated at all.

Software reaches a small register window to restrict allocation. Every master has two way masks, one for data and one for instruction fetches. A set bit in a mask keeps that way out of allocation for that master and access type. The block also keeps a per-set, per-way line lock. When line locking is switched on, every line allocated is locked in its set. A line lock keeps its way out of allocation for all masters. An unlock command walks through all sets, one set per cycle, and clears the line locks of the ways it names.

Among the allowed ways, the block takes an empty way first. When no allowed way is empty, it picks a way from a free-running pseudo-random sequence. If the masks leave only one way, that way is always chosen.

Top module: `way_victim_sel`

## Requirements
- R1: After reset, all way masks are zero and no line lock is set. Line locking is off, `busy` and `res_valid` are low, and the random generator holds 16'hACE1.
- R2: The data mask of master n is at address 0x900+8n and its instruction mask is at 0x904+8n. Only the low WAYS bits are stored. Reading back returns the stored mask with all upper bits zero.
- R3: A way is ineligible when its bit is set in the mask for the requesting master and access type (`req_instr`=1 selects the instruction mask). The masks of other masters, and the mask of the other access type, have no effect.
- R4: If any eligible way has its `req_line_valid` bit clear, the victim is the lowest-index such way.
- R5: If every eligible way is valid, the scan starts at the way given by the low log2(WAYS) bits of the 16-bit generator. It moves upward modulo WAYS and stops at the first eligible way. The generator takes one step per request, shifting left and inserting bit15^bit13^bit12^bit10.
- R6: When no way is eligible, `res_noalloc` is 1 for that response.
- R7: `res_valid`, `res_way` and `res_noalloc` appear on the cycle after the request cycle.
- R8: Bit 0 at address 0x950 enables line locking, and that address reads back the bit. While the bit is set, an allocated victim becomes line-locked in its set at the same clock edge. A line-locked way is ineligible whether or not the bit is set.
- R9: A write to 0x954 while idle starts a sweep. `busy` stays high for SETS cycles. In the k-th busy cycle, set k loses its line locks in the ways named in the write. A read of 0x954 returns that way list while busy and 0 otherwise. A write to 0x954 while busy is ignored.
- R10: A sweep may clear a set in the same cycle that an allocation locks a line in that set. The clearing applies first, so the new lock survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| req_valid | input | 1 | Victim request strobe |
| req_set | input | log2(SETS) | Set index of the linefill |
| req_master | input | 3 | Requesting master ID |
| req_instr | input | 1 | 1 for instruction fetch, 0 for data |
| req_line_valid | input | WAYS | Valid bit of each way in the set |
| res_valid | output | 1 | Response strobe |
| res_way | output | log2(WAYS) | Chosen victim way |
| res_noalloc | output | 1 | No way may be allocated |
| busy | output | 1 | Unlock sweep in progress |

## Verification
The collision of interest is an allocation that sets a line lock in a set while the unlock sweep clears that same set in the same cycle. The bench provokes it in a directed case: it issues a request to set 0 in the first busy cycle after an unlock-all write. Afterwards it checks that the freshly locked way is still skipped. Random traffic also mixes sweeps with line-locking allocations. A cycle-accurate bench model applies the clear before the lock, and every response is compared against that model.

// File: rtl/way_victim_sel.sv
module way_victim_sel #(
  parameter int WAYS = 8,
  parameter int SETS = 16,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [11:0]             cfg_addr,
  input  logic [31:0]             cfg_wdata,
  output logic [31:0]             cfg_rdata,
  input  logic                    req_valid,
  input  logic [$clog2(SETS)-1:0] req_set,
  input  logic [2:0]              req_master,
  input  logic                    req_instr,
  input  logic [WAYS-1:0]         req_line_valid,
  output logic                    res_valid,
  output logic [$clog2(WAYS)-1:0] res_way,
  output logic                    res_noalloc,
  output logic                    busy
);
  localparam int LW = $clog2(WAYS);
  localparam int SW = $clog2(SETS);

  logic [WAYS-1:0] dmask [8];
  logic [WAYS-1:0] imask [8];
  logic [WAYS-1:0] lines [SETS];
  logic [WAYS-1:0] lines_nxt [SETS];
  logic            line_en;
  logic [SW-1:0]   sw_idx;
  logic [WAYS-1:0] sw_ways;
  logic [15:0]     lfsr;
  logic [WAYS-1:0] row_q, lock_q;

  wire hit_mask = cfg_addr[11:6] == 6'h24;
  wire hit_en   = cfg_addr[11:2] == 10'h254;
  wire hit_unl  = cfg_addr[11:2] == 10'h255;

  wire [WAYS-1:0] cur_row  = lines[req_set];
  wire [WAYS-1:0] cur_lock = req_instr ? imask[req_master] : dmask[req_master];
  wire [WAYS-1:0] elig     = ~cur_lock & ~cur_row;
  wire [WAYS-1:0] empty    = elig & ~req_line_valid;
  wire            noalloc  = ~|elig;
  wire            fb       = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  logic [LW-1:0] pick, probe;
  logic          found;
  always_comb begin
    pick  = '0;
    probe = '0;
    found = 1'b0;
    if (|empty) begin
      for (int k = 0; k < WAYS; k++)
        if (!found && empty[k]) begin pick = LW'(k); found = 1'b1; end
    end else begin
      for (int k = 0; k < WAYS; k++) begin
        probe = lfsr[LW-1:0] + LW'(k);
        if (!found && elig[probe]) begin pick = probe; found = 1'b1; end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      lines_nxt[s] = lines[s];
      if (busy && sw_idx == SW'(s)) lines_nxt[s] = lines_nxt[s] & ~sw_ways;
      if (req_valid && line_en && !noalloc && req_set == SW'(s)) lines_nxt[s][pick] = 1'b1;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (hit_mask)     cfg_rdata[WAYS-1:0] = cfg_addr[2] ? imask[cfg_addr[5:3]] : dmask[cfg_addr[5:3]];
    else if (hit_en)  cfg_rdata[0] = line_en;
    else if (hit_unl) cfg_rdata[WAYS-1:0] = busy ? sw_ways : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < 8; m++) begin dmask[m] <= '0; imask[m] <= '0; end
      for (int s = 0; s < SETS; s++) lines[s] <= '0;
      line_en     <= 1'b0;
      busy        <= 1'b0;
      sw_idx      <= '0;
      sw_ways     <= '0;
      lfsr        <= SEED;
      res_valid   <= 1'b0;
      res_way     <= '0;
      res_noalloc <= 1'b0;
      row_q       <= '0;
      lock_q      <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) lines[s] <= lines_nxt[s];
      if (cfg_we && hit_mask) begin
        if (cfg_addr[2]) imask[cfg_addr[5:3]] <= cfg_wdata[WAYS-1:0];
        else             dmask[cfg_addr[5:3]] <= cfg_wdata[WAYS-1:0];
      end
      if (cfg_we && hit_en) line_en <= cfg_wdata[0];
      if (busy) begin
        sw_idx <= sw_idx + 1'b1;
        if (sw_idx == SW'(SETS-1)) begin busy <= 1'b0; sw_ways <= '0; end
      end else if (cfg_we && hit_unl) begin
        busy    <= 1'b1;
        sw_idx  <= '0;
        sw_ways <= cfg_wdata[WAYS-1:0];
      end
      res_valid <= req_valid;
      if (req_valid) begin
        res_way     <= pick;
        res_noalloc <= noalloc;
        row_q       <= cur_row;
        lock_q      <= cur_lock;
        lfsr        <= {lfsr[14:0], fb};
      end
    end
  end

  assert_resp_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid));
  assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0);
  assert_victim_not_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_noalloc) |-> !lock_q[res_way]);
  assert_victim_not_linelocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_noalloc) |-> !row_q[res_way]);
  assert_sweep_starts_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_we && hit_unl));
  assert_sweep_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sw_idx == SW'(SETS-1)) |=> !busy);
endmodule

// File: tb/tb_way_victim_sel.sv
module tb_way_victim_sel;
  localparam int WAYS = 8;
  localparam int SETS = 16;
  localparam int LW = $clog2(WAYS);
  localparam int SW = $clog2(SETS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic req_valid = 1'b0;
  logic [SW-1:0] req_set = '0;
  logic [2:0] req_master = '0;
  logic req_instr = 1'b0;
  logic [WAYS-1:0] req_line_valid = '0;
  logic res_valid, res_noalloc, busy;
  logic [LW-1:0] res_way;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  way_victim_sel #(.WAYS(WAYS), .SETS(SETS)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_set(req_set), .req_master(req_master),
    .req_instr(req_instr), .req_line_valid(req_line_valid), .res_valid(res_valid),
    .res_way(res_way), .res_noalloc(res_noalloc), .busy(busy));

  logic [WAYS-1:0] m_d [8];
  logic [WAYS-1:0] m_i [8];
  logic [WAYS-1:0] m_row [SETS];
  bit m_en, m_busy;
  int m_idx;
  logic [WAYS-1:0] m_ways;
  logic [15:0] m_lfsr;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model_pick(output int way, output bit na, output string tag);
    logic [WAYS-1:0] lk = req_instr ? m_i[req_master] : m_d[req_master];
    logic [WAYS-1:0] el = ~lk & ~m_row[req_set];
    int j;
    way = 0; na = (el == 0); tag = "R6";
    if (na) return;
    for (int k = 0; k < WAYS; k++)
      if (el[k] && !req_line_valid[k]) begin way = k; tag = "R4"; return; end
    j = m_lfsr % WAYS;
    while (!el[j]) j = (j + 1) % WAYS;
    way = j; tag = "R5";
  endfunction

  task automatic tick();
    int way; bit na, ev, was_busy; string tag;
    ev = req_valid; was_busy = m_busy;
    if (ev) model_pick(way, na, tag);
    if (m_busy) begin
      m_row[m_idx] = m_row[m_idx] & ~m_ways;
      if (m_idx == SETS - 1) m_busy = 0;
      m_idx++;
    end
    if (ev) begin
      if (m_en && !na) m_row[req_set][way] = 1'b1;
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
    if (cfg_we) begin
      if (cfg_addr >= 12'h900 && cfg_addr < 12'h940) begin
        if (((cfg_addr - 12'h900) % 8) >= 4) m_i[(cfg_addr - 12'h900) / 8] = cfg_wdata[WAYS-1:0];
        else m_d[(cfg_addr - 12'h900) / 8] = cfg_wdata[WAYS-1:0];
      end
      if (cfg_addr == 12'h950) m_en = cfg_wdata[0];
      if (cfg_addr == 12'h954 && !was_busy) begin m_busy = 1; m_idx = 0; m_ways = cfg_wdata[WAYS-1:0]; end
    end
    @(posedge clk);
    @(negedge clk);
    check("R7 res_valid", {31'b0, res_valid}, {31'b0, ev});
    if (ev) begin
      check({tag, " R6 noalloc"}, {31'b0, res_noalloc}, {31'b0, na});
      if (!na) check({tag, " R3 way"}, 32'(res_way), 32'(way));
    end
    check("R9 busy", {31'b0, busy}, {31'b0, m_busy});
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic rd(string tag, logic [11:0] a, logic [31:0] exp);
    cfg_addr = a; #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic rq(int s, int m, bit ins, logic [WAYS-1:0] v);
    req_valid = 1; req_set = SW'(s); req_master = 3'(m); req_instr = ins; req_line_valid = v;
    tick();
    req_valid = 0;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int m = 0; m < 8; m++) begin m_d[m] = '0; m_i[m] = '0; end
    for (int s = 0; s < SETS; s++) m_row[s] = '0;
    m_en = 0; m_busy = 0; m_idx = 0; m_ways = '0; m_lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check("R1 res_valid", {31'b0, res_valid}, 32'h0);
    check("R1 busy", {31'b0, busy}, 32'h0);
    rd("R1 mask", 12'h908, 32'h0);
    rd("R1 line_en", 12'h950, 32'h0);

    wr(12'h918, 32'hFFFF_FF05); rd("R2 data mask 3", 12'h918, 32'h05);
    wr(12'h91C, 32'h0000_01A0); rd("R2 instr mask 3", 12'h91C, 32'hA0);
    rd("R2 other master", 12'h910, 32'h0);
    rq(0, 3, 0, 8'h0B);
    rq(0, 3, 1, 8'h00);
    rq(0, 2, 0, 8'h00);
    wr(12'h918, 32'hFE);
    rq(1, 3, 0, 8'hFF);
    rq(1, 3, 0, 8'hFF);
    rq(1, 4, 0, 8'hFF);
    rq(1, 4, 1, 8'hFF);
    wr(12'h918, 32'hFF);
    rq(1, 3, 0, 8'h00);
    wr(12'h918, 32'h00);

    wr(12'h950, 32'h1); rd("R8 line_en", 12'h950, 32'h1);
    rq(5, 0, 0, 8'h00);
    rq(5, 0, 0, 8'h00);
    wr(12'h950, 32'h0);
    rq(5, 0, 0, 8'h00);
    rq(5, 1, 1, 8'h00);

    wr(12'h954, 32'h01);
    rd("R9 read busy ways", 12'h954, 32'h01);
    wr(12'h954, 32'hFF);
    rd("R9 write ignored", 12'h954, 32'h01);
    while (m_busy) tick();
    rd("R9 idle read", 12'h954, 32'h0);
    rq(5, 0, 0, 8'h01);
    rq(5, 0, 0, 8'h00);

    wr(12'h950, 32'h1);
    wr(12'h954, 32'hFF);
    rq(0, 0, 0, 8'h00);
    while (m_busy) tick();
    rq(0, 0, 0, 8'h00);
    check("R10 lock survived", {31'b0, m_row[0][0]}, 32'h1);

    for (int it = 0; it < 600; it++) begin
      int r = $urandom % 20;
      if (r == 0) wr(12'h900 + 12'($urandom % 16) * 12'h4, $urandom & $urandom);
      else if (r == 1) wr(12'h950, $urandom % 2);
      else if (r == 2 && !m_busy) wr(12'h954, $urandom);
      else if (r == 3) rq($urandom % SETS, $urandom % 8, $urandom % 2, 8'hFF);
      else rq($urandom % SETS, $urandom % 8, $urandom % 2, WAYS'($urandom | $urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule